// File: doc/BRIEF.md
# Chained descriptor DMA source engine

This block is a single memory-to-FIFO DMA channel that moves 128-bit quadwords from a memory read port into a downstream input FIFO. It runs in one of two modes. In linear mode it copies one contiguous run of quadwords from a start address. In chain mode it walks a list of descriptor tags held in memory. Each tag gives a quadword count, an optional data pointer and a rule that selects where the next tag is found.

Software starts the channel by pulsing a start strobe together with the mode, the addresses, the 32-bit count word and a 4-bit snapshot of the last tag. The snapshot lets a chain resume in the middle of a list. The channel keeps at most one memory read in flight. It parks returned data in a one-entry holding register until the FIFO accepts it. When the transfer finishes, or when the start word is rejected, it raises a one-cycle interrupt pulse. A stop strobe withdraws the channel's run bit. Reads already issued still deliver their data, and no new read is issued after that.

Top module: `qdc_chain_src`

## Requirements
- R1: Every quadword moved is the memory word at the current data address. After it returns, the data address rises by 16 and the remaining count falls by 1.
- R2: In linear mode (cfg_chain=0) with a nonzero count N, the channel pushes the N words from cfg_madr upward in address order, then pulses irq once and drops ch_active.
- R3: In chain mode a tag costs exactly one memory read at the tag address. Tag fields: count in bits 15:0, kind in bits 30:28, interrupt flag in bit 31, pointer in bits 63:32.
- R4: Kind 1 (continue) moves data from tag address + 16. When its count is exhausted, the next tag address becomes the address just past the data.
- R5: Kind 2 (jump) moves data from tag address + 16. When its count is exhausted, the next tag address becomes the tag's pointer.
- R6: Kind 3 (gather) moves data from the tag's pointer, and the tag address advances by 16 to the following tag.
- R7: Kind 0 (gather-last) moves data from the tag's pointer and advances the tag address by 16. The chain then completes after that data.
- R8: Kind 7 (stop) moves data from tag address + 16 and advances the tag address by 16. The chain then completes after that data.
- R9: With cfg_tag_irq_en=1, a tag whose bit 31 is set completes the chain after its data. With cfg_tag_irq_en=0, that bit has no effect.
- R10: A chain start with a nonzero count resumes a tag. The kind comes from cfg_last_tag[2:0], and the chain completes after that data only if cfg_last_tag[3] AND cfg_tag_irq_en. A chain start with a zero count fetches a tag at cfg_tadr.
- R11: A linear start with a zero count moves nothing. It pulses irq on the next cycle and leaves ch_active low.
- R12: A start word whose upper 16 bits (cfg_count[31:16]) are nonzero clears the count, moves nothing, leaves the channel stopped and pulses irq.
- R13: No word is pushed while fifo_full is high, and none is lost or duplicated under backpressure. At most one read is outstanding, and a returned word never overwrites an unsent one.
- R14: A stop strobe prevents any further memory read. A word already in flight is still delivered, and no completion interrupt follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Start strobe, taken only while idle |
| cfg_stop | input | 1 | Clears the run bit |
| cfg_chain | input | 1 | 1 selects chain mode, 0 linear mode |
| cfg_tag_irq_en | input | 1 | Enables the per-tag completion flag |
| cfg_count | input | 32 | Count in [15:0], must-be-zero field in [31:16] |
| cfg_madr | input | 32 | Data address at start |
| cfg_tadr | input | 32 | Tag address at start |
| cfg_last_tag | input | 4 | Resume snapshot: [2:0] kind, [3] interrupt flag |
| mem_req | output | 1 | Read request, one cycle |
| mem_addr | output | 32 | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 128 | Read data |
| fifo_full | input | 1 | Downstream FIFO cannot accept |
| fifo_wr | output | 1 | Push strobe |
| fifo_data | output | 128 | Pushed quadword |
| ch_active | output | 1 | Run bit |
| ch_madr | output | 32 | Current data address |
| ch_tadr | output | 32 | Current tag address |
| ch_count | output | 16 | Remaining quadwords of the current run |
| irq | output | 1 | Channel interrupt pulse |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 128-bit quadwords, a 16-bit count and a 16-bit must-be-zero field. The memory model decodes a 256-quadword window, which keeps every tag list and data run small enough to set up and check word by word. FIFO backpressure comes from 8-cycle full masks of several densities, which reach both the back-to-back issue path and the parked-word path. Fixed tag lists cover every kind, the completion flag with and without its enable, both resume forms, the two rejected start words and a stop with a word in flight.

// File: rtl/qdc_pkg.sv
package qdc_pkg;
  // Tag kind encodings (bits 30:28 of a tag)
  localparam logic [2:0] TK_REFE = 3'd0;
  localparam logic [2:0] TK_CNT  = 3'd1;
  localparam logic [2:0] TK_NEXT = 3'd2;
  localparam logic [2:0] TK_REF  = 3'd3;
  localparam logic [2:0] TK_END  = 3'd7;

  localparam int TAG_ID_LSB   = 28;
  localparam int TAG_IRQ_BIT  = 31;
  localparam int TAG_ADDR_LSB = 32;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TAG_REQ,
    S_TAG_WAIT,
    S_XFER,
    S_TAG_DONE
  } state_e;
endpackage

// File: rtl/qdc_tag_decode.sv
module qdc_tag_decode
  import qdc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int QW_W   = 128,
  parameter int CNT_W  = 16
) (
  input  logic [QW_W-1:0]   tag_word,
  input  logic [ADDR_W-1:0] tag_addr,
  output logic [CNT_W-1:0]  t_count,
  output logic [2:0]        t_kind,
  output logic              t_irq,
  output logic [ADDR_W-1:0] t_ptr,
  output logic [ADDR_W-1:0] t_data_addr,
  output logic [ADDR_W-1:0] t_follow,
  output logic              t_last
);
  localparam int QW_BYTES = QW_W / 8;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(QW_BYTES);

  logic [ADDR_W-1:0] after_tag;
  logic unused_tag_bits;

  assign t_count   = tag_word[CNT_W-1:0];
  assign t_kind    = tag_word[TAG_ID_LSB +: 3];
  assign t_irq     = tag_word[TAG_IRQ_BIT];
  assign t_ptr     = tag_word[TAG_ADDR_LSB +: ADDR_W];
  assign after_tag = tag_addr + STEP;
  assign unused_tag_bits = ^{tag_word[QW_W-1:TAG_ADDR_LSB+ADDR_W], tag_word[TAG_ID_LSB-1:CNT_W]};

  always_comb begin
    t_data_addr = after_tag;
    t_follow    = after_tag;
    t_last      = 1'b0;
    case (t_kind)
      TK_REF: begin
        t_data_addr = t_ptr;
      end
      TK_REFE: begin
        t_data_addr = t_ptr;
        t_last      = 1'b1;
      end
      TK_CNT, TK_NEXT: begin
        // the tag address is resolved when the data run is exhausted
        t_follow = tag_addr;
      end
      default: begin
        t_last = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/qdc_hold_buf.sv
module qdc_hold_buf #(
  parameter int QW_W = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [QW_W-1:0] load_data,
  input  logic            fifo_full,
  output logic            hold_valid,
  output logic            fifo_wr,
  output logic [QW_W-1:0] fifo_data
);
  logic            valid_q, valid_d;
  logic [QW_W-1:0] data_q;

  assign hold_valid = valid_q;
  assign fifo_wr    = valid_q & ~fifo_full;
  assign fifo_data  = data_q;

  always_comb begin
    valid_d = valid_q;
    if (fifo_wr) valid_d = 1'b0;
    if (load)    valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (load) data_q <= load_data;
    end
  end

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!valid_q || fifo_wr)); // R13
endmodule

// File: rtl/qdc_chain_fsm.sv
module qdc_chain_fsm
  import qdc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int QW_W   = 128,
  parameter int CNT_W  = 16,
  parameter int PAD_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_start,
  input  logic                    cfg_stop,
  input  logic                    cfg_chain,
  input  logic                    cfg_tag_irq_en,
  input  logic [CNT_W+PAD_W-1:0]  cfg_count,
  input  logic [ADDR_W-1:0]       cfg_madr,
  input  logic [ADDR_W-1:0]       cfg_tadr,
  input  logic [3:0]              cfg_last_tag,
  input  logic                    mem_rvalid,
  input  logic [CNT_W-1:0]        t_count,
  input  logic [2:0]              t_kind,
  input  logic                    t_irq,
  input  logic [ADDR_W-1:0]       t_ptr,
  input  logic [ADDR_W-1:0]       t_data_addr,
  input  logic [ADDR_W-1:0]       t_follow,
  input  logic                    t_last,
  input  logic                    hold_valid,
  input  logic                    fifo_wr,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    hold_load,
  output logic                    ch_active,
  output logic [ADDR_W-1:0]       ch_madr,
  output logic [ADDR_W-1:0]       ch_tadr,
  output logic [CNT_W-1:0]        ch_count,
  output logic                    irq
);
  localparam int QW_BYTES = QW_W / 8;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(QW_BYTES);

  state_e            state_q, state_d;
  logic              chain_q, chain_d;
  logic              tie_q, tie_d;
  logic              fin_q, fin_d;
  logic              act_q, act_d;
  logic              pend_q, pend_d;
  logic              irq_q, irq_d;
  logic [2:0]        kind_q, kind_d;
  logic [ADDR_W-1:0] madr_q, madr_d;
  logic [ADDR_W-1:0] tadr_q, tadr_d;
  logic [ADDR_W-1:0] nxt_q, nxt_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  logic              pad_bad;
  logic              cnt_zero_in;

  assign pad_bad     = (cfg_count[CNT_W +: PAD_W] != '0);
  assign cnt_zero_in = (cfg_count[CNT_W-1:0] == '0);

  always_comb begin
    state_d   = state_q;
    chain_d   = chain_q;
    tie_d     = tie_q;
    fin_d     = fin_q;
    act_d     = act_q;
    pend_d    = pend_q;
    irq_d     = 1'b0;
    kind_d    = kind_q;
    madr_d    = madr_q;
    tadr_d    = tadr_q;
    nxt_d     = nxt_q;
    cnt_d     = cnt_q;
    mem_req   = 1'b0;
    mem_addr  = madr_q;
    hold_load = 1'b0;

    // data quadword returning from memory
    if (state_q == S_XFER && pend_q && mem_rvalid) begin
      madr_d    = madr_q + STEP;
      cnt_d     = cnt_q - 1'b1;
      pend_d    = 1'b0;
      hold_load = 1'b1;
    end

    case (state_q)
      S_IDLE: begin
        if (cfg_start) begin
          if (pad_bad) begin
            cnt_d = '0;
            irq_d = 1'b1;
            act_d = 1'b0;
          end else if (!cfg_chain && cnt_zero_in) begin
            irq_d = 1'b1;
            act_d = 1'b0;
          end else begin
            madr_d  = cfg_madr;
            cnt_d   = cfg_count[CNT_W-1:0];
            chain_d = cfg_chain;
            tie_d   = cfg_tag_irq_en;
            act_d   = 1'b1;
            if (!cfg_chain) begin
              fin_d   = 1'b1;
              state_d = S_XFER;
            end else if (cnt_zero_in) begin
              tadr_d  = cfg_tadr;
              fin_d   = 1'b0;
              state_d = S_TAG_REQ;
            end else begin
              tadr_d  = cfg_tadr;
              kind_d  = cfg_last_tag[2:0];
              fin_d   = cfg_last_tag[3] & cfg_tag_irq_en;
              state_d = S_XFER;
            end
          end
        end
      end

      S_TAG_REQ: begin
        if (!act_q) begin
          state_d = S_IDLE;
        end else begin
          mem_req  = 1'b1;
          mem_addr = tadr_q;
          pend_d   = 1'b1;
          state_d  = S_TAG_WAIT;
        end
      end

      S_TAG_WAIT: begin
        if (mem_rvalid) begin
          pend_d  = 1'b0;
          cnt_d   = t_count;
          kind_d  = t_kind;
          madr_d  = t_data_addr;
          tadr_d  = t_follow;
          nxt_d   = t_ptr;
          fin_d   = fin_q | t_last | (tie_q & t_irq);
          state_d = S_XFER;
        end
      end

      S_XFER: begin
        if (!pend_q) begin
          if (cnt_q == '0) begin
            state_d = S_TAG_DONE;
            if (chain_q) begin
              case (kind_q)
                TK_CNT:  tadr_d = madr_q;
                TK_NEXT: tadr_d = nxt_q;
                default: tadr_d = tadr_q;
              endcase
            end
          end else if (!act_q) begin
            state_d = S_IDLE;
          end else if (!hold_valid || fifo_wr) begin
            mem_req = 1'b1;
            pend_d  = 1'b1;
          end
        end
      end

      S_TAG_DONE: begin
        if (!fin_q) begin
          state_d = S_TAG_REQ;
        end else if (!hold_valid) begin
          irq_d   = 1'b1;
          act_d   = 1'b0;
          state_d = S_IDLE;
        end
      end

      default: state_d = S_IDLE;
    endcase

    if (cfg_stop) act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      chain_q <= 1'b0;
      tie_q   <= 1'b0;
      fin_q   <= 1'b0;
      act_q   <= 1'b0;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
      kind_q  <= '0;
      madr_q  <= '0;
      tadr_q  <= '0;
      nxt_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      chain_q <= chain_d;
      tie_q   <= tie_d;
      fin_q   <= fin_d;
      act_q   <= act_d;
      pend_q  <= pend_d;
      irq_q   <= irq_d;
      kind_q  <= kind_d;
      madr_q  <= madr_d;
      tadr_q  <= tadr_d;
      nxt_q   <= nxt_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ch_active = act_q;
  assign ch_madr   = madr_q;
  assign ch_tadr   = tadr_q;
  assign ch_count  = cnt_q;
  assign irq       = irq_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_XFER && pend_q && mem_rvalid) |=>
      (madr_q == $past(madr_q) + STEP && cnt_q == $past(cnt_q) - 1'b1)); // R1

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req || !pend_q || mem_rvalid); // R13

  AST_STOP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_stop |=> !mem_req); // R14

  AST_IRQ_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> !act_q); // R2

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R2

  AST_PAD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && cfg_start && pad_bad) |=>
      (irq_q && cnt_q == '0 && !act_q)); // R12
endmodule

// File: rtl/qdc_chain_src.sv
module qdc_chain_src #(
  parameter int ADDR_W = 32,
  parameter int QW_W   = 128,
  parameter int CNT_W  = 16,
  parameter int PAD_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_start,
  input  logic                   cfg_stop,
  input  logic                   cfg_chain,
  input  logic                   cfg_tag_irq_en,
  input  logic [CNT_W+PAD_W-1:0] cfg_count,
  input  logic [ADDR_W-1:0]      cfg_madr,
  input  logic [ADDR_W-1:0]      cfg_tadr,
  input  logic [3:0]             cfg_last_tag,
  output logic                   mem_req,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic                   mem_rvalid,
  input  logic [QW_W-1:0]        mem_rdata,
  input  logic                   fifo_full,
  output logic                   fifo_wr,
  output logic [QW_W-1:0]        fifo_data,
  output logic                   ch_active,
  output logic [ADDR_W-1:0]      ch_madr,
  output logic [ADDR_W-1:0]      ch_tadr,
  output logic [CNT_W-1:0]       ch_count,
  output logic                   irq
);
  logic [CNT_W-1:0]  t_count;
  logic [2:0]        t_kind;
  logic              t_irq;
  logic [ADDR_W-1:0] t_ptr;
  logic [ADDR_W-1:0] t_data_addr;
  logic [ADDR_W-1:0] t_follow;
  logic              t_last;
  logic              hold_valid;
  logic              hold_load;

  qdc_tag_decode #(.ADDR_W(ADDR_W), .QW_W(QW_W), .CNT_W(CNT_W)) u_dec (
    .tag_word    (mem_rdata),
    .tag_addr    (ch_tadr),
    .t_count     (t_count),
    .t_kind      (t_kind),
    .t_irq       (t_irq),
    .t_ptr       (t_ptr),
    .t_data_addr (t_data_addr),
    .t_follow    (t_follow),
    .t_last      (t_last)
  );

  qdc_chain_fsm #(.ADDR_W(ADDR_W), .QW_W(QW_W), .CNT_W(CNT_W), .PAD_W(PAD_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_start      (cfg_start),
    .cfg_stop       (cfg_stop),
    .cfg_chain      (cfg_chain),
    .cfg_tag_irq_en (cfg_tag_irq_en),
    .cfg_count      (cfg_count),
    .cfg_madr       (cfg_madr),
    .cfg_tadr       (cfg_tadr),
    .cfg_last_tag   (cfg_last_tag),
    .mem_rvalid     (mem_rvalid),
    .t_count        (t_count),
    .t_kind         (t_kind),
    .t_irq          (t_irq),
    .t_ptr          (t_ptr),
    .t_data_addr    (t_data_addr),
    .t_follow       (t_follow),
    .t_last         (t_last),
    .hold_valid     (hold_valid),
    .fifo_wr        (fifo_wr),
    .mem_req        (mem_req),
    .mem_addr       (mem_addr),
    .hold_load      (hold_load),
    .ch_active      (ch_active),
    .ch_madr        (ch_madr),
    .ch_tadr        (ch_tadr),
    .ch_count       (ch_count),
    .irq            (irq)
  );

  qdc_hold_buf #(.QW_W(QW_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (hold_load),
    .load_data  (mem_rdata),
    .fifo_full  (fifo_full),
    .hold_valid (hold_valid),
    .fifo_wr    (fifo_wr),
    .fifo_data  (fifo_data)
  );
endmodule

// File: tb/qdc_chain_src_tb_top.sv
module qdc_chain_src_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_start, cfg_stop, cfg_chain, cfg_tag_irq_en;
  logic [31:0]  cfg_count, cfg_madr, cfg_tadr;
  logic [3:0]   cfg_last_tag;
  logic         mem_req;
  logic [31:0]  mem_addr;
  logic         mem_rvalid;
  logic [127:0] mem_rdata;
  logic         fifo_full;
  logic         fifo_wr;
  logic [127:0] fifo_data;
  logic         ch_active;
  logic [31:0]  ch_madr, ch_tadr;
  logic [15:0]  ch_count;
  logic         irq;

  always #10 clk = ~clk;

  qdc_chain_src dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_stop(cfg_stop),
    .cfg_chain(cfg_chain), .cfg_tag_irq_en(cfg_tag_irq_en), .cfg_count(cfg_count),
    .cfg_madr(cfg_madr), .cfg_tadr(cfg_tadr), .cfg_last_tag(cfg_last_tag),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .ch_active(ch_active), .ch_madr(ch_madr), .ch_tadr(ch_tadr), .ch_count(ch_count),
    .irq(irq)
  );

  logic [127:0] mem [0:255];
  logic [127:0] got [$];
  int           expq [$];
  int           irq_cnt, req_cnt;
  int           checks = 0;
  int           fails  = 0;
  logic [31:0]  cyc = 0;
  logic [7:0]   stall_mask = 8'h00;
  logic         force_full = 1'b0;

  assign fifo_full = force_full | stall_mask[cyc[2:0]];

  always @(negedge clk) cyc <= cyc + 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= mem_req;
      mem_rdata  <= mem[mem_addr[11:4]];
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (fifo_wr) got.push_back(fifo_data);
      if (irq)     irq_cnt++;
      if (mem_req) req_cnt++;
    end
  end

  // Normal-mode vectors: {start index, count, full mask}
  localparam logic [23:0] NTAB [0:5] = '{
    24'h80_01_00, 24'h80_04_00, 24'hA0_05_AA,
    24'hB0_03_F0, 24'hC0_06_7E, 24'h01_10_33
  };

  function automatic logic [127:0] mk_tag(input logic [2:0] id, input logic irqb,
                                          input logic [15:0] n, input logic [31:0] a);
    return {64'h0, a, irqb, id, 12'h000, n};
  endfunction

  task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic clear_mon();
    got.delete();
    expq.delete();
    irq_cnt = 0;
    req_cnt = 0;
  endtask

  task automatic launch(input logic chain, input logic tie, input logic [31:0] cnt,
                        input logic [31:0] madr, input logic [31:0] tadr, input logic [3:0] last);
    @(negedge clk);
    cfg_chain      = chain;
    cfg_tag_irq_en = tie;
    cfg_count      = cnt;
    cfg_madr       = madr;
    cfg_tadr       = tadr;
    cfg_last_tag   = last;
    cfg_start      = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
  endtask

  task automatic wait_irq();
    int n = 0;
    while (irq_cnt == 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_stream(input string what);
    chk({what, " word count"}, 128'(got.size()), 128'(expq.size()));
    for (int k = 0; k < expq.size() && k < got.size(); k++)
      chk($sformatf("%s word %0d", what, k), got[k], mem[expq[k]]);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_start = 0; cfg_stop = 0; cfg_chain = 0; cfg_tag_irq_en = 0;
    cfg_count = 0; cfg_madr = 0; cfg_tadr = 0; cfg_last_tag = 0;
    irq_cnt = 0; req_cnt = 0;
    for (int i = 0; i < 256; i++) mem[i] = {4{24'hA5C3E1, 8'(i)}};
    mem[8'h10] = mk_tag(3'd1, 1'b0, 16'd2, 32'h0);
    mem[8'h13] = mk_tag(3'd2, 1'b0, 16'd1, 32'h400);
    mem[8'h40] = mk_tag(3'd3, 1'b0, 16'd2, 32'h800);
    mem[8'h41] = mk_tag(3'd0, 1'b0, 16'd1, 32'h900);
    mem[8'h20] = mk_tag(3'd7, 1'b0, 16'd2, 32'h0);
    mem[8'h30] = mk_tag(3'd1, 1'b1, 16'd1, 32'h0);
    mem[8'h32] = mk_tag(3'd7, 1'b0, 16'd1, 32'h0);
    mem[8'h52] = mk_tag(3'd7, 1'b0, 16'd0, 32'h0);

    repeat (3) @(negedge clk);
    // Reset state
    chk("reset ch_active", 128'(ch_active), 128'(0));
    chk("reset irq", 128'(irq), 128'(0));
    chk("reset mem_req", 128'(mem_req), 128'(0));
    chk("reset fifo_wr", 128'(fifo_wr), 128'(0));
    chk("reset ch_count", 128'(ch_count), 128'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 / R1 / R13: linear mode vectors under several backpressure patterns
    for (int v = 0; v < 6; v++) begin
      logic [7:0] sidx, scnt;
      sidx = NTAB[v][23:16];
      scnt = NTAB[v][15:8];
      clear_mon();
      stall_mask = NTAB[v][7:0];
      for (int k = 0; k < int'(scnt); k++) expq.push_back((int'(sidx) + k) % 256);
      launch(1'b0, 1'b0, 32'(scnt), 32'(sidx) << 4, 32'h0, 4'h0);
      wait_irq();
      stall_mask = 8'h00;
      chk_stream($sformatf("R2 R13 vector %0d", v));
      chk($sformatf("R1 vector %0d final madr", v), 128'(ch_madr), 128'((32'(sidx) + 32'(scnt)) << 4));
      chk($sformatf("R1 vector %0d final count", v), 128'(ch_count), 128'(0));
      chk($sformatf("R2 vector %0d irq pulses", v), 128'(irq_cnt), 128'(1));
      chk($sformatf("R2 vector %0d stopped", v), 128'(ch_active), 128'(0));
    end

    // R3 R4 R5 R6 R7: cnt -> next -> ref -> refe list
    clear_mon();
    stall_mask = 8'h5A;
    expq = '{8'h11, 8'h12, 8'h14, 8'h80, 8'h81, 8'h90};
    launch(1'b1, 1'b0, 32'h0, 32'h0, 32'h100, 4'h0);
    wait_irq();
    stall_mask = 8'h00;
    chk_stream("R4 R5 R6 R7 chain");
    chk("R7 chain final tadr", 128'(ch_tadr), 128'(32'h420));
    chk("R7 chain final madr", 128'(ch_madr), 128'(32'h910));
    chk("R3 chain reads", 128'(req_cnt), 128'(10));
    chk("R7 chain irq", 128'(irq_cnt), 128'(1));

    // R8 / R3: single stop-kind tag
    clear_mon();
    expq = '{8'h21, 8'h22};
    launch(1'b1, 1'b0, 32'h0, 32'h0, 32'h200, 4'h0);
    wait_irq();
    chk_stream("R8 stop tag");
    chk("R8 stop tag tadr", 128'(ch_tadr), 128'(32'h210));
    chk("R3 stop tag reads", 128'(req_cnt), 128'(3));

    // R9: tag flag with enable set completes after its data
    clear_mon();
    expq = '{8'h31};
    launch(1'b1, 1'b1, 32'h0, 32'h0, 32'h300, 4'h0);
    wait_irq();
    chk_stream("R9 flag enabled");
    chk("R9 flag enabled tadr", 128'(ch_tadr), 128'(32'h320));
    chk("R9 flag enabled irq", 128'(irq_cnt), 128'(1));

    // R9: tag flag ignored without enable
    clear_mon();
    expq = '{8'h31, 8'h33};
    launch(1'b1, 1'b0, 32'h0, 32'h0, 32'h300, 4'h0);
    wait_irq();
    chk_stream("R9 flag disabled");
    chk("R9 flag disabled tadr", 128'(ch_tadr), 128'(32'h330));

    // R10: resume a continue-kind tag, not finished, then fetch next tag
    clear_mon();
    expq = '{8'h50, 8'h51};
    launch(1'b1, 1'b0, 32'h2, 32'h500, 32'h600, 4'b0001);
    wait_irq();
    chk_stream("R10 resume open");
    chk("R10 resume open tadr", 128'(ch_tadr), 128'(32'h530));
    chk("R10 resume open reads", 128'(req_cnt), 128'(3));

    // R10: resume with flag and enable -> finishes without tag read
    clear_mon();
    expq = '{8'h50, 8'h51};
    launch(1'b1, 1'b1, 32'h2, 32'h500, 32'h600, 4'b1001);
    wait_irq();
    chk_stream("R10 resume finished");
    chk("R10 resume finished tadr", 128'(ch_tadr), 128'(32'h520));
    chk("R10 resume finished reads", 128'(req_cnt), 128'(2));

    // R11: linear start with zero count
    clear_mon();
    launch(1'b0, 1'b0, 32'h0, 32'h800, 32'h0, 4'h0);
    repeat (4) @(negedge clk);
    chk("R11 zero count irq", 128'(irq_cnt), 128'(1));
    chk("R11 zero count stopped", 128'(ch_active), 128'(0));
    chk("R11 zero count pushes", 128'(got.size()), 128'(0));
    chk("R11 zero count reads", 128'(req_cnt), 128'(0));

    // R12: nonzero upper field
    clear_mon();
    launch(1'b0, 1'b0, 32'h0001_0004, 32'h800, 32'h0, 4'h0);
    repeat (4) @(negedge clk);
    chk("R12 pad irq", 128'(irq_cnt), 128'(1));
    chk("R12 pad count cleared", 128'(ch_count), 128'(0));
    chk("R12 pad stopped", 128'(ch_active), 128'(0));
    chk("R12 pad pushes", 128'(got.size()), 128'(0));

    // R14 / R13: stop with one word parked behind a full FIFO
    clear_mon();
    force_full = 1'b1;
    launch(1'b0, 1'b0, 32'h8, 32'h800, 32'h0, 4'h0);
    repeat (6) @(negedge clk);
    chk("R13 no push while full", 128'(got.size()), 128'(0));
    cfg_stop = 1'b1;
    @(negedge clk);
    cfg_stop = 1'b0;
    repeat (2) @(negedge clk);
    chk("R14 reads before release", 128'(req_cnt), 128'(1));
    force_full = 1'b0;
    repeat (10) @(negedge clk);
    chk("R14 in-flight word delivered", 128'(got.size()), 128'(1));
    if (got.size() > 0) chk("R14 delivered data", got[0], mem[8'h80]);
    chk("R14 no further reads", 128'(req_cnt), 128'(1));
    chk("R14 no irq", 128'(irq_cnt), 128'(0));
    chk("R14 stopped", 128'(ch_active), 128'(0));
    chk("R14 remaining count", 128'(ch_count), 128'(7));
    chk("R14 madr", 128'(ch_madr), 128'(32'h810));

    summary();
    $finish;
  end
endmodule